// File: doc/BRIEF.md
# Microprogram Address Sequencer

This block chooses the microcode ROM address for the next machine cycle. It holds the current microinstruction address in a register. On each cycle-advance strobe it loads that register from one of several sources: the incremented address, a branch target carried in the microinstruction, a single saved return address, a loop-controlled target, a target taken when a selected condition status bit is set, or a dispatch address.

The dispatch source runs at each macroinstruction boundary. A pending hold request sends the sequencer to a fixed hold service address. Failing that, a pending interrupt sends it to a fixed interrupt service address. With neither pending, it enters the mapped start address of the next macroinstruction. A down-counter, loaded from the microinstruction, lets one microinstruction branch back a set number of times before falling through. The microcode store and the mapping table are outside the block.

Top module: `uaddr_sequencer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the address, the saved return address and the loop count all become zero, so `uaddr` reads 0x000 after the edge.
- R2: Operation code 0 (continue) loads the current address plus one, wrapping from 0xFFF to 0x000.
- R3: Operation code 1 (branch) loads `br_tgt`.
- R4: Operation code 2 (call) loads `br_tgt` and stores the current address plus one (wrapping) as the single return address, overwriting any earlier one. Operation code 3 (return) loads the stored return address.
- R5: Operation code 4 (loop) loads `br_tgt` and decrements the loop count when the count is nonzero. When the count is zero it loads the current address plus one.
- R6: `cnt_ld` with an advance loads `cnt_val` into the loop count and overrides a loop decrement in the same cycle. The branch decision of a loop operation in that cycle still uses the old count.
- R7: Operation code 5 (conditional branch) tests the bit of `cond_flags` chosen by `cond_sel`. The bit positions are carry or no-borrow = 0, positive = 1, zero = 2, negative = 3. It loads `br_tgt` if that bit is 1 and the current address plus one otherwise.
- R8: Operation code 6 (dispatch) loads `HOLD_VEC` if `hold_req` is set, else `IRQ_VEC` if `irq_pend` is set, else `map_addr`.
- R9: With `adv` low, no state changes, whatever the other inputs are, including `cnt_ld`.
- R10: Operation code 7 behaves as continue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| adv | input | 1 | Cycle-advance strobe, one per machine cycle |
| nxt_op | input | 3 | Next-address operation code |
| br_tgt | input | ADDR_W | Branch, call and loop target |
| map_addr | input | ADDR_W | Mapped start address of the next macroinstruction |
| cnt_ld | input | 1 | Load the loop count |
| cnt_val | input | CNT_W | Loop count load value |
| cond_flags | input | 4 | Condition status bits (carry, positive, zero, negative) |
| cond_sel | input | 2 | Index of the condition bit to test |
| hold_req | input | 1 | Hold request pending |
| irq_pend | input | 1 | Interrupt pending |
| uaddr | output | ADDR_W | Current microcode address |

## Verification
The bench keeps the 12-bit address width, so a branch to 0xFFF followed by a continue or a call reaches the wrap to 0x000. It narrows `CNT_W` to 4, which lets it sweep every loop count from 0 to 15 and confirm that each one branches exactly that many times before falling through. It sets `HOLD_VEC` to 0xFF0 and `IRQ_VEC` to 0xFE0, which differ from each other and from the mapped addresses it uses, so all four hold and interrupt combinations can be told apart. It also sweeps all 16 flag patterns against all 4 selects for the conditional branch.

// File: rtl/uaddr_pkg.sv
package uaddr_pkg;

    typedef enum logic [2:0] {
        OP_CONT = 3'd0,
        OP_BR   = 3'd1,
        OP_CALL = 3'd2,
        OP_RET  = 3'd3,
        OP_LOOP = 3'd4,
        OP_CBR  = 3'd5,
        OP_MAP  = 3'd6,
        OP_RSV  = 3'd7
    } nxt_op_e;

    localparam int NUM_FLAGS = 4;
    localparam int FLAG_SEL_W = $clog2(NUM_FLAGS);

    // flag positions inside the condition status vector
    localparam int FLG_CARRY = 0;
    localparam int FLG_POS   = 1;
    localparam int FLG_ZERO  = 2;
    localparam int FLG_NEG   = 3;

endpackage

// File: rtl/useq_incr.sv
module useq_incr #(
    parameter int W = 12
) (
    input  logic [W-1:0] a,
    output logic [W-1:0] y
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    always_comb begin
        y = a + ONE;
    end
endmodule

// File: rtl/useq_cond_mux.sv
module useq_cond_mux #(
    parameter int N  = 4,
    parameter int SW = $clog2(N)
) (
    input  logic [N-1:0]  flags,
    input  logic [SW-1:0] sel,
    output logic          taken
);
    logic [N-1:0] hit;

    for (genvar i = 0; i < N; i++) begin : g_sel
        assign hit[i] = flags[i] && (sel == SW'(i));
    end

    always_comb begin
        taken = |hit;
    end
endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch #(
    parameter int                W        = 12,
    parameter logic [W-1:0]      HOLD_VEC = '0,
    parameter logic [W-1:0]      IRQ_VEC  = '0
) (
    input  logic         hold_req,
    input  logic         irq_pend,
    input  logic [W-1:0] map_addr,
    output logic [W-1:0] disp_addr
);
    always_comb begin
        if (hold_req) begin
            disp_addr = HOLD_VEC;
        end else if (irq_pend) begin
            disp_addr = IRQ_VEC;
        end else begin
            disp_addr = map_addr;
        end
    end
endmodule

// File: rtl/uaddr_sequencer.sv
module uaddr_sequencer
    import uaddr_pkg::*;
#(
    parameter int                 ADDR_W   = 12,
    parameter int                 CNT_W    = 8,
    parameter logic [ADDR_W-1:0]  HOLD_VEC = 12'hFF0,
    parameter logic [ADDR_W-1:0]  IRQ_VEC  = 12'hFE0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  adv,
    input  logic [2:0]            nxt_op,
    input  logic [ADDR_W-1:0]     br_tgt,
    input  logic [ADDR_W-1:0]     map_addr,
    input  logic                  cnt_ld,
    input  logic [CNT_W-1:0]      cnt_val,
    input  logic [NUM_FLAGS-1:0]  cond_flags,
    input  logic [FLAG_SEL_W-1:0] cond_sel,
    input  logic                  hold_req,
    input  logic                  irq_pend,
    output logic [ADDR_W-1:0]     uaddr
);
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] save;
        logic [CNT_W-1:0]  cnt;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic [ADDR_W-1:0] addr_inc;
    logic [ADDR_W-1:0] disp_addr;
    logic              cond_taken;
    logic              cnt_nz;
    nxt_op_e           op;

    assign op     = nxt_op_e'(nxt_op);
    assign cnt_nz = |st_q.cnt;

    useq_incr #(.W(ADDR_W)) u_incr (
        .a (st_q.addr),
        .y (addr_inc)
    );

    useq_cond_mux #(.N(NUM_FLAGS), .SW(FLAG_SEL_W)) u_cond (
        .flags (cond_flags),
        .sel   (cond_sel),
        .taken (cond_taken)
    );

    useq_dispatch #(.W(ADDR_W), .HOLD_VEC(HOLD_VEC), .IRQ_VEC(IRQ_VEC)) u_disp (
        .hold_req  (hold_req),
        .irq_pend  (irq_pend),
        .map_addr  (map_addr),
        .disp_addr (disp_addr)
    );

    always_comb begin
        st_d = st_q;
        if (adv) begin
            unique case (op)
                OP_BR:   st_d.addr = br_tgt;
                OP_CALL: begin
                    st_d.addr = br_tgt;
                    st_d.save = addr_inc;
                end
                OP_RET:  st_d.addr = st_q.save;
                OP_LOOP: begin
                    if (cnt_nz) begin
                        st_d.addr = br_tgt;
                        st_d.cnt  = st_q.cnt - CNT_ONE;
                    end else begin
                        st_d.addr = addr_inc;
                    end
                end
                OP_CBR:  st_d.addr = cond_taken ? br_tgt : addr_inc;
                OP_MAP:  st_d.addr = disp_addr;
                default: st_d.addr = addr_inc;
            endcase
            if (cnt_ld) begin
                st_d.cnt = cnt_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign uaddr = st_q.addr;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (uaddr == '0)); // R1

    AST_SEQ_INCR: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && nxt_op == 3'd0) |=> (uaddr == ADDR_W'($past(uaddr) + 1'b1))); // R2

    AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && nxt_op == 3'd1) |=> (uaddr == $past(br_tgt))); // R3

    AST_RETURN_SAVED: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && nxt_op == 3'd2) ##1 (adv && nxt_op == 3'd3) |=>
        (uaddr == ADDR_W'($past(uaddr, 2) + 1'b1))); // R4

    AST_LOOP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && nxt_op == 3'd4 && st_q.cnt == '0) |=>
        (uaddr == ADDR_W'($past(uaddr) + 1'b1))); // R5

    AST_COND_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && nxt_op == 3'd5 && cond_flags[cond_sel]) |=> (uaddr == $past(br_tgt))); // R7

    AST_HOLD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && nxt_op == 3'd6 && hold_req) |=> (uaddr == HOLD_VEC)); // R8

    AST_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> ($stable(uaddr) && $stable(st_q.cnt) && $stable(st_q.save))); // R9

endmodule

// File: tb/uaddr_sequencer_tb.sv
module uaddr_sequencer_tb;
    localparam int AW = 12;
    localparam int CW = 4;
    localparam logic [AW-1:0] HV = 12'hFF0;
    localparam logic [AW-1:0] IV = 12'hFE0;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          adv = 1'b0;
    logic [2:0]    nxt_op = 3'd0;
    logic [AW-1:0] br_tgt = '0;
    logic [AW-1:0] map_addr = '0;
    logic          cnt_ld = 1'b0;
    logic [CW-1:0] cnt_val = '0;
    logic [3:0]    cond_flags = '0;
    logic [1:0]    cond_sel = '0;
    logic          hold_req = 1'b0;
    logic          irq_pend = 1'b0;
    logic [AW-1:0] uaddr;

    int tests = 0;
    int fails = 0;

    logic [AW-1:0] e_addr = '0;
    logic [AW-1:0] e_save = '0;
    logic [CW-1:0] e_cnt = '0;

    always #2 clk = ~clk;

    uaddr_sequencer #(.ADDR_W(AW), .CNT_W(CW), .HOLD_VEC(HV), .IRQ_VEC(IV)) u_dut (
        .clk(clk), .rst_n(rst_n), .adv(adv), .nxt_op(nxt_op), .br_tgt(br_tgt),
        .map_addr(map_addr), .cnt_ld(cnt_ld), .cnt_val(cnt_val),
        .cond_flags(cond_flags), .cond_sel(cond_sel), .hold_req(hold_req),
        .irq_pend(irq_pend), .uaddr(uaddr)
    );

    task automatic chk(input string rq, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: uaddr=%03h expected=%03h", rq, act, exp);
        end
    endtask

    // advance one clock with the inputs now driven; update model and compare
    task automatic tick(input string rq);
        logic [AW-1:0] inc;
        logic [AW-1:0] na;
        logic [AW-1:0] ns;
        logic [CW-1:0] nc;
        inc = e_addr + 1'b1;
        na = e_addr; ns = e_save; nc = e_cnt;
        if (adv) begin
            case (nxt_op)
                3'd1: na = br_tgt;
                3'd2: begin na = br_tgt; ns = inc; end
                3'd3: na = e_save;
                3'd4: if (e_cnt != 0) begin na = br_tgt; nc = e_cnt - 1'b1; end
                      else na = inc;
                3'd5: na = cond_flags[cond_sel] ? br_tgt : inc;
                3'd6: na = hold_req ? HV : (irq_pend ? IV : map_addr);
                default: na = inc;
            endcase
            if (cnt_ld) nc = cnt_val;
        end
        e_addr = na; e_save = ns; e_cnt = nc;
        @(posedge clk);
        #1;
        chk(rq, uaddr, e_addr);
    endtask

    task automatic op(input logic [2:0] o, input logic [AW-1:0] t, input string rq);
        adv = 1'b1; nxt_op = o; br_tgt = t;
        tick(rq);
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog: uaddr=%03h expected=end of run", uaddr);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R1 reset
        repeat (3) @(posedge clk);
        #1;
        chk("R1", uaddr, 12'h000);
        rst_n = 1'b1;

        // R2 sequential stepping
        for (int i = 0; i < 5; i++) op(3'd0, 12'h000, "R2");
        // R3 branch, then R2 wrap at top
        op(3'd1, 12'hFFF, "R3");
        op(3'd0, 12'h000, "R2");
        op(3'd1, 12'h2A5, "R3");
        // R10 reserved code acts as continue
        op(3'd7, 12'h123, "R10");

        // R4 call / return, including wrap of saved address and overwrite
        op(3'd2, 12'h400, "R4");
        op(3'd0, 12'h000, "R2");
        op(3'd3, 12'h000, "R4");
        op(3'd1, 12'hFFF, "R3");
        op(3'd2, 12'h500, "R4");
        op(3'd2, 12'h600, "R4");
        op(3'd3, 12'h000, "R4");
        chk("R4", uaddr, 12'h501);

        // R5/R6 loop sweep over every count
        for (int n = 0; n < 16; n++) begin
            op(3'd1, 12'h100, "R3");
            cnt_ld = 1'b1; cnt_val = CW'(n);
            op(3'd0, 12'h000, "R6");
            cnt_ld = 1'b0;
            op(3'd1, 12'h100, "R3");
            for (int k = 0; k <= n; k++) op(3'd4, 12'h100, "R5");
            chk("R5", uaddr, 12'h101);
        end

        // R6 load overrides the decrement in the same cycle
        cnt_ld = 1'b1; cnt_val = 4'd3; op(3'd0, 12'h000, "R6");
        cnt_val = 4'd0; op(3'd4, 12'h200, "R6");
        cnt_ld = 1'b0;
        op(3'd4, 12'h300, "R6");

        // R9 stall: nothing moves, loop count load ignored
        cnt_ld = 1'b1; cnt_val = 4'd2; op(3'd0, 12'h000, "R6");
        adv = 1'b0;
        for (int i = 0; i < 8; i++) begin
            nxt_op = 3'(i); br_tgt = 12'hABC; cnt_val = 4'd9; hold_req = 1'b1;
            tick("R9");
        end
        cnt_ld = 1'b0; hold_req = 1'b0;
        for (int k = 0; k < 3; k++) op(3'd4, 12'h700, "R9");

        // R7 conditional branch sweep
        for (int f = 0; f < 16; f++) begin
            for (int s = 0; s < 4; s++) begin
                cond_flags = 4'(f); cond_sel = 2'(s);
                op(3'd5, 12'h050 + 12'(f * 4 + s), "R7");
            end
        end

        // R8 dispatch priority
        for (int h = 0; h < 2; h++) begin
            for (int q = 0; q < 2; q++) begin
                hold_req = h[0]; irq_pend = q[0]; map_addr = 12'h3C0 + 12'(h * 2 + q);
                op(3'd6, 12'h000, "R8");
            end
        end
        hold_req = 1'b0; irq_pend = 1'b0;

        // R1 reset mid-run clears save and count too
        op(3'd2, 12'h444, "R4");
        cnt_ld = 1'b1; cnt_val = 4'd5; op(3'd0, 12'h000, "R6");
        cnt_ld = 1'b0;
        rst_n = 1'b0; adv = 1'b0;
        @(posedge clk); #1;
        e_addr = '0; e_save = '0; e_cnt = '0;
        chk("R1", uaddr, 12'h000);
        rst_n = 1'b1;
        op(3'd3, 12'h000, "R1");
        op(3'd4, 12'h777, "R1");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule